// File: doc/BRIEF.md
# Unicast and Multicast Matching Merger

This block sits at the back end of a crossbar scheduler in which a multicast scheduler and a bank of unicast allocators work independently and in parallel. Once per cell slot, marked by a slot strobe, it picks the unicast allocator whose matching epoch is ending and combines that matching with the multicast matching into one conflict-free crossbar setting. Multicast connections always win. A unicast connection that shares an input or an output with any multicast connection is removed from the setting.

The removed unicast connections are held as a remainder. While the remainder is held, the block filters the raw unicast and multicast requests it passes to the schedulers. Every request that would collide with a remainder connection is removed, and the remainder connection itself is kept. Those connections then find their inputs and outputs free in the matchings computed from the filtered requests, so unicast traffic is not starved and no fixed service ratio is needed.

The selected allocator's matching gives one destination index and a valid bit per input. The multicast matching gives one output fanout bitmap per input. The merged grant gives, for each output, a valid bit, the source input and a multicast flag.

Top module: `mcast_merge`

## Requirements
- R1: While reset is asserted and after it, until the first slot strobe, all grant valid bits are 0, the remainder is empty and the filtered requests equal the raw requests.
- R2: Slot strobes select unicast allocators in rotation: the first strobe after reset uses allocator 0, and each further strobe uses the next allocator, wrapping from K-1 to 0. Allocator a, input i uses valid bit a*N+i and destination field bits (a*N+i)*IW upward.
- R3: One clock after a slot strobe, every output o whose bit i*N+o is set in the multicast fanout shows grant valid 1, source i and multicast flag 1.
- R4: One clock after a slot strobe, each valid unicast connection (i,d) whose input i has an empty fanout and whose output d is in no fanout shows at output d as grant valid 1, source i and multicast flag 0.
- R5: A valid unicast connection that shares its input or its output with a multicast connection is not granted.
- R6: The connections dropped under R5 form the remainder, loaded on the slot strobe. While it is held, unicast request bit i*N+j is passed only if neither input i nor output j belongs to a remainder connection, or (i,j) is itself a remainder connection.
- R7: While the remainder is held, multicast request bit i*N+j is passed only if input i and output j both lie outside every remainder connection.
- R8: A slot with no dropped connection empties the remainder, after which both filtered request vectors equal the raw ones.
- R9: Without a slot strobe the grants and the remainder keep their values.
- R10: In the merged setting no two granted outputs share a source input unless both are multicast grants.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| slotEn | input | 1 | Cell slot strobe: merge and load this cycle |
| ucMatchVld | input | K*N | Per allocator, per input connection valid |
| ucMatchDst | input | K*N*IW | Per allocator, per input destination output index |
| mcFanout | input | N*N | Multicast matching, bit i*N+o: input i feeds output o |
| ucReq | input | N*N | Raw unicast requests, bit i*N+j |
| mcReq | input | N*N | Raw multicast requests, bit i*N+j |
| grantVld | output | N | Per output: connection present |
| grantSrc | output | N*IW | Per output: source input index |
| grantMc | output | N | Per output: connection is multicast |
| ucReqFilt | output | N*N | Filtered unicast requests |
| mcReqFilt | output | N*N | Filtered multicast requests |

## Verification
Grants and the remainder are registered, so they are due on the clock edge that samples the slot strobe. The bench reads them half a period later, at the falling edge that follows. The filtered requests depend combinationally on the raw requests and on the remainder register. They change whenever the bench drives new raw requests, and the remainder loaded on the previous edge takes effect at the same time. The bench therefore drives inputs on the falling edge and compares every output one nanosecond later against a behavioural model. That model advances its allocator index and its remainder only on rising edges that carry the strobe.

// File: rtl/mcast_merge_pkg.sv
package mcast_merge_pkg;
  typedef struct packed {
    logic load;
  } slotCtl_t;
endpackage

// File: rtl/mcast_merge_ctl.sv
module mcast_merge_ctl
  import mcast_merge_pkg::*;
#(
  parameter int K = 4,
  parameter int KW = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          slotEn,
  output slotCtl_t      ctl,
  output logic [KW-1:0] selIdx
);
  localparam logic [KW-1:0] LAST = KW'(K - 1);

  assign ctl.load = slotEn;

  always_ff @(posedge clk) begin
    if (rst) selIdx <= '0;
    else if (slotEn) selIdx <= (selIdx == LAST) ? '0 : selIdx + 1'b1;
  end

  // R2: the rotating index never leaves the allocator range
  assert_sel_range_R2: assert property (@(posedge clk) disable iff (rst)
    selIdx <= LAST);
endmodule

// File: rtl/mcast_merge_path.sv
module mcast_merge_path
  import mcast_merge_pkg::*;
#(
  parameter int N = 8,
  parameter int K = 4,
  parameter int IW = 3,
  parameter int KW = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  slotCtl_t        ctl,
  input  logic [KW-1:0]   selIdx,
  input  logic [K*N-1:0]  ucMatchVld,
  input  logic [K*N*IW-1:0] ucMatchDst,
  input  logic [N*N-1:0]  mcFanout,
  input  logic [N*N-1:0]  ucReq,
  input  logic [N*N-1:0]  mcReq,
  output logic [N-1:0]    grantVld,
  output logic [N*IW-1:0] grantSrc,
  output logic [N-1:0]    grantMc,
  output logic [N*N-1:0]  ucReqFilt,
  output logic [N*N-1:0]  mcReqFilt
);
  logic [N-1:0]    mcIn, mcOut, selV, keep;
  logic [N*IW-1:0] selD;
  logic [N-1:0]    nVld, nMc;
  logic [N*IW-1:0] nSrc;
  logic [N-1:0]    remVld, remOut;
  logic [N*IW-1:0] remDst;

  // pick the matching of the allocator whose epoch ends now
  always_comb begin
    for (int i = 0; i < N; i++) begin
      selV[i] = ucMatchVld[int'(selIdx)*N + i];
      selD[i*IW +: IW] = ucMatchDst[(int'(selIdx)*N + i)*IW +: IW];
    end
  end

  // multicast occupancy and merge
  always_comb begin
    mcOut = '0;
    for (int i = 0; i < N; i++) begin
      mcIn[i] = |mcFanout[i*N +: N];
      mcOut = mcOut | mcFanout[i*N +: N];
    end
    nVld = '0;
    nMc  = '0;
    nSrc = '0;
    for (int i = 0; i < N; i++) begin
      keep[i] = selV[i] && !mcIn[i] && !mcOut[selD[i*IW +: IW]];
      for (int o = 0; o < N; o++) begin
        if (mcFanout[i*N + o]) begin
          nVld[o] = 1'b1;
          nMc[o]  = 1'b1;
          nSrc[o*IW +: IW] = IW'(i);
        end
      end
      if (keep[i]) begin
        nVld[selD[i*IW +: IW]] = 1'b1;
        nSrc[int'(selD[i*IW +: IW])*IW +: IW] = IW'(i);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      grantVld <= '0;
      grantMc  <= '0;
      grantSrc <= '0;
      remVld   <= '0;
      remDst   <= '0;
    end else if (ctl.load) begin
      grantVld <= nVld;
      grantMc  <= nMc;
      grantSrc <= nSrc;
      remVld   <= selV & ~keep;
      remDst   <= selD;
    end
  end

  // request filter driven by the held remainder
  always_comb begin
    remOut = '0;
    for (int i = 0; i < N; i++)
      if (remVld[i]) remOut[remDst[i*IW +: IW]] = 1'b1;
    for (int i = 0; i < N; i++) begin
      for (int j = 0; j < N; j++) begin
        ucReqFilt[i*N + j] = ucReq[i*N + j] &&
          (!(remVld[i] || remOut[j]) ||
           (remVld[i] && remDst[i*IW +: IW] == IW'(j)));
        mcReqFilt[i*N + j] = mcReq[i*N + j] && !remVld[i] && !remOut[j];
      end
    end
  end

  assert_hold_R9: assert property (@(posedge clk) disable iff (rst)
    !ctl.load |=> $stable(grantVld) && $stable(grantSrc) && $stable(remVld));

  assert_filter_subset_R6: assert property (@(posedge clk) disable iff (rst)
    ((ucReqFilt & ~ucReq) == '0) && ((mcReqFilt & ~mcReq) == '0));

  assert_empty_pass_R8: assert property (@(posedge clk) disable iff (rst)
    (remVld == '0) |-> (ucReqFilt == ucReq) && (mcReqFilt == mcReq));

  for (genvar i = 0; i < N; i++) begin : g_rem
    // R5: a dropped connection is never also granted as unicast
    assert_dropped_absent_R5: assert property (@(posedge clk) disable iff (rst)
      remVld[i] |-> !(grantVld[remDst[i*IW +: IW]] && !grantMc[remDst[i*IW +: IW]] &&
                      grantSrc[int'(remDst[i*IW +: IW])*IW +: IW] == IW'(i)));
  end

  for (genvar o = 0; o < N; o++) begin : g_pa
    for (genvar p = o + 1; p < N; p++) begin : g_pb
      assert_one_source_R10: assert property (@(posedge clk) disable iff (rst)
        (grantVld[o] && grantVld[p] && !(grantMc[o] && grantMc[p])) |->
          grantSrc[o*IW +: IW] != grantSrc[p*IW +: IW]);
    end
  end
endmodule

// File: rtl/mcast_merge.sv
module mcast_merge
  import mcast_merge_pkg::*;
#(
  parameter int N = 8,
  parameter int K = 4,
  localparam int IW = (N > 1) ? $clog2(N) : 1,
  localparam int KW = (K > 1) ? $clog2(K) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              slotEn,
  input  logic [K*N-1:0]    ucMatchVld,
  input  logic [K*N*IW-1:0] ucMatchDst,
  input  logic [N*N-1:0]    mcFanout,
  input  logic [N*N-1:0]    ucReq,
  input  logic [N*N-1:0]    mcReq,
  output logic [N-1:0]      grantVld,
  output logic [N*IW-1:0]   grantSrc,
  output logic [N-1:0]      grantMc,
  output logic [N*N-1:0]    ucReqFilt,
  output logic [N*N-1:0]    mcReqFilt
);
  slotCtl_t      ctl;
  logic [KW-1:0] selIdx;

  mcast_merge_ctl #(.K(K), .KW(KW)) ctl_i (
    .clk(clk), .rst(rst), .slotEn(slotEn), .ctl(ctl), .selIdx(selIdx)
  );

  mcast_merge_path #(.N(N), .K(K), .IW(IW), .KW(KW)) path_i (
    .clk(clk), .rst(rst), .ctl(ctl), .selIdx(selIdx),
    .ucMatchVld(ucMatchVld), .ucMatchDst(ucMatchDst), .mcFanout(mcFanout),
    .ucReq(ucReq), .mcReq(mcReq),
    .grantVld(grantVld), .grantSrc(grantSrc), .grantMc(grantMc),
    .ucReqFilt(ucReqFilt), .mcReqFilt(mcReqFilt)
  );
endmodule

// File: tb/mcast_merge_tb.sv
`timescale 1ns/1ps
module mcast_merge_tb_top;
  localparam int N = 8;
  localparam int K = 4;
  localparam int IW = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic slotEn = 1'b0;
  logic [K*N-1:0]    ucMatchVld = '0;
  logic [K*N*IW-1:0] ucMatchDst = '0;
  logic [N*N-1:0]    mcFanout = '0;
  logic [N*N-1:0]    ucReq = '0;
  logic [N*N-1:0]    mcReq = '0;
  logic [N-1:0]      grantVld;
  logic [N*IW-1:0]   grantSrc;
  logic [N-1:0]      grantMc;
  logic [N*N-1:0]    ucReqFilt;
  logic [N*N-1:0]    mcReqFilt;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  mcast_merge #(.N(N), .K(K)) dut_i (.*);

  // behavioural reference
  int mVld[N], mSrc[N], mMc[N], mRemV[N], mRemD[N];
  int mSlot = 0;
  bit prevLoad = 0;
  int dropSeen = 0;

  always @(posedge clk) begin
    prevLoad = slotEn && !rst;
    if (rst) begin
      for (int o = 0; o < N; o++) begin
        mVld[o] = 0; mSrc[o] = 0; mMc[o] = 0; mRemV[o] = 0; mRemD[o] = 0;
      end
      mSlot = 0;
    end else if (slotEn) begin
      for (int o = 0; o < N; o++) begin
        mVld[o] = 0; mSrc[o] = 0; mMc[o] = 0;
      end
      for (int i = 0; i < N; i++)
        for (int o = 0; o < N; o++)
          if (mcFanout[i*N+o]) begin mVld[o] = 1; mSrc[o] = i; mMc[o] = 1; end
      for (int i = 0; i < N; i++) begin
        int d;
        bit busy;
        d = int'(ucMatchDst[(mSlot*N+i)*IW +: IW]);
        busy = (mcFanout[i*N +: N] != 0);
        for (int k = 0; k < N; k++) if (mcFanout[k*N+d]) busy = 1;
        mRemD[i] = d;
        mRemV[i] = 0;
        if (ucMatchVld[mSlot*N+i]) begin
          if (busy) begin mRemV[i] = 1; dropSeen++; end
          else begin mVld[d] = 1; mSrc[d] = i; mMc[d] = 0; end
        end
      end
      mSlot = (mSlot + 1) % K;
    end
  end

  task automatic chk(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare(input bit inReset);
    logic [N-1:0] eV, eM;
    logic [N*IW-1:0] eS;
    logic [N*N-1:0] eU, eC;
    bit remOut[N];
    bit anyRem;
    int srcCnt[N];
    anyRem = 0;
    for (int o = 0; o < N; o++) begin
      eV[o] = mVld[o][0]; eM[o] = mMc[o][0]; eS[o*IW +: IW] = IW'(mSrc[o]);
      remOut[o] = 0;
    end
    for (int i = 0; i < N; i++) if (mRemV[i] != 0) begin remOut[mRemD[i]] = 1; anyRem = 1; end
    for (int i = 0; i < N; i++)
      for (int j = 0; j < N; j++) begin
        bit blocked;
        blocked = (mRemV[i] != 0) || remOut[j];
        eU[i*N+j] = ucReq[i*N+j] && (!blocked || (mRemV[i] != 0 && mRemD[i] == j));
        eC[i*N+j] = mcReq[i*N+j] && (mRemV[i] == 0) && !remOut[j];
      end
    if (inReset) begin
      chk("R1 grantVld", longint'(grantVld), 0);
      chk("R1 ucReqFilt", longint'(ucReqFilt), longint'(ucReq));
      return;
    end
    if (!prevLoad) chk("R9 held grantVld", longint'(grantVld), longint'(eV));
    else chk("R2 R3 R4 R5 grantVld", longint'(grantVld), longint'(eV));
    chk("R3 grantMc", longint'(grantMc & grantVld), longint'(eM & eV));
    chk("R2 R4 grantSrc", longint'(grantSrc & {N{1'b1}}'(0) | masked(grantSrc, grantVld)),
        longint'(masked(eS, eV)));
    if (anyRem) begin
      chk("R6 ucReqFilt", longint'(ucReqFilt), longint'(eU));
      chk("R7 mcReqFilt", longint'(mcReqFilt), longint'(eC));
    end else begin
      chk("R8 ucReqFilt", longint'(ucReqFilt), longint'(ucReq));
      chk("R8 mcReqFilt", longint'(mcReqFilt), longint'(mcReq));
    end
    for (int i = 0; i < N; i++) srcCnt[i] = 0;
    for (int o = 0; o < N; o++)
      if (grantVld[o] && !grantMc[o]) srcCnt[grantSrc[o*IW +: IW]] += 2;
      else if (grantVld[o]) srcCnt[grantSrc[o*IW +: IW]] += 1;
    for (int i = 0; i < N; i++) begin
      bit bad;
      bad = 0;
      for (int o = 0; o < N; o++)
        if (grantVld[o] && !grantMc[o] && grantSrc[o*IW +: IW] == IW'(i) && srcCnt[i] > 2) bad = 1;
      chk("R10 shared source", longint'(bad), 0);
    end
  endtask

  function automatic logic [N*IW-1:0] masked(input logic [N*IW-1:0] s, input logic [N-1:0] v);
    logic [N*IW-1:0] r;
    for (int o = 0; o < N; o++) r[o*IW +: IW] = v[o] ? s[o*IW +: IW] : '0;
    return r;
  endfunction

  task automatic drive_random(input int mcPct);
    for (int a = 0; a < K; a++) begin
      bit used[N];
      for (int o = 0; o < N; o++) used[o] = 0;
      for (int i = 0; i < N; i++) begin
        int d;
        d = int'($urandom % N);
        ucMatchDst[(a*N+i)*IW +: IW] = IW'(d);
        ucMatchVld[a*N+i] = 1'b0;
        if (!used[d] && ($urandom % 4) != 0) begin
          ucMatchVld[a*N+i] = 1'b1; used[d] = 1;
        end
      end
    end
    mcFanout = '0;
    for (int o = 0; o < N; o++)
      if (int'($urandom % 100) < mcPct) mcFanout[int'($urandom % 3)*N + o] = 1'b1;
    for (int b = 0; b < N*N; b++) begin
      ucReq[b] = $urandom[0];
      mcReq[b] = $urandom[0];
    end
    slotEn = ($urandom % 5) != 0;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    // R1: reset state, with requests present and strobes ignored
    repeat (3) begin
      @(negedge clk);
      ucReq = {N*N{1'b1}};
      slotEn = 1'b1;
      #1 compare(1);
    end
    @(negedge clk);
    rst = 1'b0;
    slotEn = 1'b0;
    #1 compare(0);
    // R2: directed rotation, allocator a sends input a to output a
    for (int a = 0; a < K + 2; a++) begin
      @(negedge clk);
      ucMatchVld = '0;
      mcFanout = '0;
      for (int k = 0; k < K; k++) begin
        ucMatchVld[k*N+k] = 1'b1;
        ucMatchDst[(k*N+k)*IW +: IW] = IW'(k);
      end
      slotEn = 1'b1;
      #1 compare(0);
    end
    // R5 R6: directed input and output conflicts
    @(negedge clk);
    mcFanout = '0;
    mcFanout[0*N+5] = 1'b1;
    for (int k = 0; k < K; k++) begin
      ucMatchVld[k*N +: N] = '0;
      ucMatchVld[k*N+0] = 1'b1; ucMatchDst[(k*N+0)*IW +: IW] = 3'd1;
      ucMatchVld[k*N+2] = 1'b1; ucMatchDst[(k*N+2)*IW +: IW] = 3'd5;
      ucMatchVld[k*N+3] = 1'b1; ucMatchDst[(k*N+3)*IW +: IW] = 3'd6;
    end
    ucReq = {N*N{1'b1}};
    mcReq = {N*N{1'b1}};
    #1 compare(0);
    @(negedge clk);
    slotEn = 1'b0;
    #1 compare(0);
    // R8: clean slot empties the remainder
    @(negedge clk);
    mcFanout = '0;
    slotEn = 1'b1;
    #1 compare(0);
    @(negedge clk);
    slotEn = 1'b0;
    #1 compare(0);
    for (int c = 0; c < 4000; c++) begin
      @(negedge clk);
      drive_random((c < 2000) ? 30 : 8);
      #1 compare(0);
    end
    chk("R5 drops exercised", longint'(dropSeen > 0), 1);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule